// File: doc/BRIEF.md
# Memory Self-Test Controller with Two Start Sources

This block tests a single-port synchronous RAM of parameterised depth and width. A run fills every word with all ones and reads each word back, then fills every word with all zeros and reads each word back. Every read word is compared against the expected pattern. Any mismatch sets a fail flag that stays set until the next run begins. Because the last pattern written is zero, the RAM is left cleared when the run ends.

A run can be started by a one-cycle request from a test-access controller or by a one-cycle pulse from a control-register start bit. Both sources share one sequencer. The pass/fail result goes to different places depending on the source. The status result bit is updated by every run. The one-bit test-access result register is updated only by runs that the test-access controller started; after such a run it holds the result so that it can be shifted out.

Top module: `mbist_ctrl`

## Requirements
- R1: A high `tap_start` while `busy` is low starts a run, and `busy` is high from the next clock.
- R2: A high `reg_start` while `busy` is low starts a run, and `busy` is high from the next clock.
- R3: At the end of a run started by `tap_start`, both `stat_pass` and `tap_pass` take the result.
- R4: At the end of a run started by `reg_start`, `stat_pass` takes the result and `tap_pass` keeps its previous value.
- R5: When a run ends, every RAM word holds zero.
- R6: A run writes all ones to every address in ascending order and reads every address back. It then does the same with all zeros. The result is 1 (pass) only if every read matches the pattern; any mismatch gives 0 (fail).
- R7: Start pulses on either input while `busy` is high are ignored. They do not change the run length or which result outputs the run updates.
- R8: `busy` stays high for exactly 4*2^ADDR_W+1 clocks. `done` pulses high for one clock, in the first clock in which `busy` is low again.
- R9: After reset, `busy`, `done`, `ram_we`, `stat_pass` and `tap_pass` are all 0.
- R10: If both start inputs are high in the same idle clock, the run counts as started by `tap_start`.
- R11: Read data arrives one clock after the address. A mismatch at the last address of the zero pass is still detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tap_start | input | 1 | Run request from the test-access controller |
| reg_start | input | 1 | Run request from the control-register start bit |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | DATA_W | RAM read data, valid one clock after the address |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-clock pulse at the end of a run |
| stat_pass | output | 1 | Status result bit, 1 = pass |
| tap_pass | output | 1 | Test-access result register, 1 = pass |

## Verification
A wrong phase or a wrong address counter shows up as a changed `busy` length, or as a RAM that is not all zero when `done` pulses. Both are visible by the end of the same run. A bad compare pipeline shows as a wrong pass bit at `done`: either a planted stuck bit is missed, or a fault-free RAM is reported as failing. A source flag that is lost or overwritten by a late start pulse shows as `tap_pass` moving after a register-started run, or staying put after a test-access run. This is visible in the cycle that `done` pulses.

// File: rtl/mbist_ctrl.sv
module mbist_ctrl #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tap_start,
  input  logic              reg_start,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_we,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              busy,
  output logic              done,
  output logic              stat_pass,
  output logic              tap_pass
);
  typedef enum logic [2:0] {IDLE, FILL1, READ1, FILL0, READ0, DRAIN} phase_t;
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};
  localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

  phase_t            phase;
  logic [ADDR_W-1:0] addr;
  logic              from_tap, fail, cmp_vld;
  logic [DATA_W-1:0] cmp_exp;
  logic              fail_now;

  assign busy      = (phase != IDLE);
  assign ram_addr  = addr;
  assign ram_we    = (phase == FILL1) || (phase == FILL0);
  assign ram_wdata = (phase == FILL1) ? ONES : '0;
  assign fail_now  = fail || (cmp_vld && (ram_rdata != cmp_exp));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_vld <= 1'b0;
      cmp_exp <= '0;
    end else begin
      cmp_vld <= (phase == READ1) || (phase == READ0);
      cmp_exp <= (phase == READ1) ? ONES : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= IDLE;
      addr      <= '0;
      from_tap  <= 1'b0;
      fail      <= 1'b0;
      done      <= 1'b0;
      stat_pass <= 1'b0;
      tap_pass  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        IDLE: if (tap_start || reg_start) begin
          phase    <= FILL1;
          addr     <= '0;
          fail     <= 1'b0;
          from_tap <= tap_start;
        end
        DRAIN: begin
          phase     <= IDLE;
          done      <= 1'b1;
          stat_pass <= !fail_now;
          if (from_tap) tap_pass <= !fail_now;
        end
        default: begin
          fail <= fail_now;
          addr <= addr + 1'b1;
          if (addr == LAST) begin
            case (phase)
              FILL1:   phase <= READ1;
              READ1:   phase <= FILL0;
              FILL0:   phase <= READ0;
              default: phase <= DRAIN;
            endcase
          end
        end
      endcase
    end
  end
endmodule

module mbist_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic tap_start,
  input logic reg_start,
  input logic ram_we,
  input logic busy,
  input logic done,
  input logic stat_pass,
  input logic tap_pass
);
  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && tap_start) |=> busy);
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_start) |=> busy);
  assert_tap_only_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tap_pass) |-> done);
  assert_stat_only_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_pass) |-> done);
  assert_write_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> busy);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

bind mbist_ctrl mbist_ctrl_chk chk_i (.*);

// File: tb/mbist_ctrl_tb_top.sv
module mbist_ctrl_tb_top;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int RUNLEN = 4 * DEPTH + 1;

  logic clk = 0, rst_n = 0, tap_start = 0, reg_start = 0;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata, ram_rdata;
  logic ram_we, busy, done, stat_pass, tap_pass;

  int errors = 0, checks = 0;
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] f_addr;
  logic [DW-1:0] f_sa0 = '0, f_sa1 = '0;
  logic exp_tap = 0;

  always #4 clk = ~clk;

  mbist_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut_i (.*);

  always_ff @(posedge clk) begin
    if (ram_we)
      mem[ram_addr] <= (ram_addr == f_addr) ? ((ram_wdata & ~f_sa0) | f_sa1) : ram_wdata;
    ram_rdata <= mem[ram_addr];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic exp_pass(input logic [DW-1:0] sa0, input logic [DW-1:0] sa1);
    return (sa0 == '0) && (sa1 == '0);
  endfunction

  function automatic logic mem_zero();
    for (int i = 0; i < DEPTH; i++) if (mem[i] != '0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic run(input bit use_tap, input bit use_reg, input int late, input string req);
    int n;
    logic pass_e;
    bit src_tap;
    pass_e = exp_pass(f_sa0, f_sa1);
    src_tap = use_tap;
    @(negedge clk);
    tap_start = use_tap; reg_start = use_reg;
    @(negedge clk);
    tap_start = 0; reg_start = 0;
    chk({req, " busy after start R1/R2"}, busy, 1);
    n = 1;
    while (!done && n < RUNLEN + 10) begin
      if (n == late) begin tap_start = 1; reg_start = 1; end
      else begin tap_start = 0; reg_start = 0; end
      @(negedge clk);
      if (busy) n++;
    end
    tap_start = 0; reg_start = 0;
    chk({req, " busy length R8 R7"}, n, RUNLEN);
    chk({req, " done with busy low R8"}, {done, busy}, 2'b10);
    chk({req, " stat_pass R6 R3 R4"}, stat_pass, pass_e);
    if (src_tap) exp_tap = pass_e;
    chk({req, " tap_pass R3 R4 R10"}, tap_pass, exp_tap);
    if (pass_e) chk({req, " memory cleared R5"}, mem_zero(), 1);
    @(negedge clk);
    chk({req, " done one clock R8"}, done, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'($urandom);
    f_addr = '0;
    repeat (3) @(negedge clk);
    chk("reset state R9", {busy, done, ram_we, stat_pass, tap_pass}, 0);
    rst_n = 1;
    @(negedge clk);
    run(0, 1, 0, "reg pass R2");
    run(1, 0, 0, "tap pass R1");
    f_sa0 = 8'h04; f_addr = 5;
    run(0, 1, 0, "reg sa0 fail R4");
    f_sa0 = 0; f_sa1 = 8'h80; f_addr = AW'(DEPTH - 1);
    run(1, 0, 0, "tap sa1 last addr R11");
    f_sa1 = 0;
    run(0, 1, 7, "reg pass late starts R7");
    run(1, 1, 0, "both starts R10");
    f_sa0 = 8'h01; f_addr = 0;
    run(0, 1, 30, "reg fail late starts R7");
    f_sa0 = 0;
    for (int k = 0; k < 12; k++) begin
      int mode = $urandom_range(0, 2);
      f_addr = AW'($urandom);
      f_sa0 = (mode == 1) ? DW'(1 << $urandom_range(0, DW - 1)) : '0;
      f_sa1 = (mode == 2) ? DW'(1 << $urandom_range(0, DW - 1)) : '0;
      run($urandom_range(0, 1), 1, $urandom_range(0, 1) ? $urandom_range(2, RUNLEN - 1) : 0,
          "random R6");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule